// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is a small multicycle processor built around a single accumulator. It holds a program counter, a memory address register, a memory data buffer, an instruction register and the accumulator. A control sequencer steps through fetch, decode and execute, and it makes one register transfer per clock. The block talks to one word-addressed memory. The memory address port is driven only by the address register, and read data enters the core only through the buffer register.

The memory read is combinational from the registered address. The buffer register therefore captures the word in the state that follows the address load. An instruction word is 16 bits. The opcode sits in bits 15:12 and a 12-bit operand address sits in bits 11:0. LOAD, ADD and MUL read their operand from memory and write the accumulator. HALT parks the sequencer. The state code, accumulator and program counter are brought out so that the cycle count of each instruction can be observed.

Top module: `acc_cpu`

## Requirements
- R1: While rst_ni is low, pc_o and acc_o read 0, mem_addr_o reads 0, state_o reads 0 and halted_o reads 0.
- R2: Fetch steps through the state codes 0 (address load), 1 (buffer capture), 2 (instruction load) and 3 (decode), in that order. In state 1, mem_addr_o equals the program counter value from state 0.
- R3: The program counter increments by one when the sequencer leaves decode, and at no other time. It therefore still holds the fetched address in states 1 and 2.
- R4: Decode reads the opcode from bits 15:12. LOAD=1, ADD=2 and MUL=3 proceed to execute states 4, 5 and 6, and in state 5 mem_addr_o equals instruction bits 11:0.
- R5: LOAD sets the accumulator to M[addr] and takes 7 cycles from state 0 back to state 0.
- R6: ADD sets the accumulator to (AC + M[addr]) mod 2^16 in 7 cycles.
- R7: MUL sets the accumulator to the low 16 bits of AC * M[addr] in 7 cycles.
- R8: Any opcode other than 1, 2, 3 or F takes 4 cycles, leaves the accumulator unchanged and advances the program counter by one.
- R9: HALT (opcode F) enters state 7 after decode. The sequencer stays there with halted_o high, and pc_o and acc_o stay frozen, even if memory contents change.
- R10: mem_addr_o changes only on the clock edge that leaves state 0 or state 4.
- R11: acc_o changes only on the clock edge that leaves state 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 12 | Memory address, driven from the address register |
| mem_rdata_i | input | 16 | Memory read word for the current address |
| state_o | output | 3 | Sequencer state code |
| halted_o | output | 1 | High while parked in the halt state |
| acc_o | output | 16 | Accumulator contents |
| pc_o | output | 12 | Program counter contents |

## Verification
Short programs are run that combine LOAD, ADD and MUL with ordinary operands. These programs separate the three execute operations and confirm that each one reads the right operand address. A second program uses operands near the top of the word range and a product wider than 16 bits, together with operand addresses near 0xFFF. This shows whether ADD and MUL wrap and whether the full 12-bit address field reaches the memory port. Opcodes 0, 4 and E are placed between real instructions to show that unknown opcodes skip execute and leave the accumulator alone. A final run holds the core in HALT and rewrites memory to show that nothing moves. Every instruction is timed cycle by cycle, which separates the 7-cycle, 4-cycle and halt paths, and address or accumulator changes outside their permitted edges are flagged.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    ST_F_MAR = 3'd0,
    ST_F_MBR = 3'd1,
    ST_F_IR  = 3'd2,
    ST_DEC   = 3'd3,
    ST_X_MAR = 3'd4,
    ST_X_MBR = 3'd5,
    ST_X_AC  = 3'd6,
    ST_HALT  = 3'd7
  } state_e;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_MUL  = 2'd2
  } alu_sel_e;

  localparam logic [OP_W-1:0] OP_LOAD = 4'h1;
  localparam logic [OP_W-1:0] OP_ADD  = 4'h2;
  localparam logic [OP_W-1:0] OP_MUL  = 4'h3;
  localparam logic [OP_W-1:0] OP_HALT = 4'hF;

  typedef struct packed {
    logic     mar_from_pc;
    logic     mar_from_ir;
    logic     mbr_ld;
    logic     ir_ld;
    logic     pc_inc;
    logic     ac_ld;
    alu_sel_e alu_sel;
  } ctrl_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [OP_W-1:0] opcode_i,
  output state_e          state_o,
  output ctrl_t           ctrl_o
);

  state_e state_q, state_d;
  logic   mem_op;

  assign mem_op = (opcode_i == OP_LOAD) || (opcode_i == OP_ADD) || (opcode_i == OP_MUL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_F_MAR: state_d = ST_F_MBR;
      ST_F_MBR: state_d = ST_F_IR;
      ST_F_IR:  state_d = ST_DEC;
      ST_DEC: begin
        if (mem_op)                     state_d = ST_X_MAR;
        else if (opcode_i == OP_HALT)   state_d = ST_HALT;
        else                            state_d = ST_F_MAR;
      end
      ST_X_MAR: state_d = ST_X_MBR;
      ST_X_MBR: state_d = ST_X_AC;
      ST_X_AC:  state_d = ST_F_MAR;
      ST_HALT:  state_d = ST_HALT;
      default:  state_d = ST_F_MAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_F_MAR;
    else         state_q <= state_d;
  end

  // One transfer per state
  always_comb begin
    ctrl_o = '0;
    unique case (state_q)
      ST_F_MAR: ctrl_o.mar_from_pc = 1'b1;
      ST_F_MBR: ctrl_o.mbr_ld      = 1'b1;
      ST_F_IR:  ctrl_o.ir_ld       = 1'b1;
      ST_DEC:   ctrl_o.pc_inc      = 1'b1;
      ST_X_MAR: ctrl_o.mar_from_ir = 1'b1;
      ST_X_MBR: ctrl_o.mbr_ld      = 1'b1;
      ST_X_AC: begin
        ctrl_o.ac_ld = 1'b1;
        case (opcode_i)
          OP_ADD:  ctrl_o.alu_sel = ALU_ADD;
          OP_MUL:  ctrl_o.alu_sel = ALU_MUL;
          default: ctrl_o.alu_sel = ALU_PASS;
        endcase
      end
      default: ;
    endcase
  end

  assign state_o = state_q;

  p_fetch_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_F_MAR |=> state_q == ST_F_MBR);
  p_fetch_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_F_MBR |=> state_q == ST_F_IR);
  p_fetch_c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_F_IR |=> state_q == ST_DEC);
  p_exec_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEC && mem_op) |=> state_q == ST_X_MAR);
  p_nop_skip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEC && !mem_op && opcode_i != OP_HALT) |=> state_q == ST_F_MAR);
  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT |=> state_q == ST_HALT);

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_sel_e          sel_i,
  output logic [DATA_W-1:0] y_o
);

  always_comb begin
    unique case (sel_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_MUL: y_o = a_i * b_i;  // low half kept
      default: y_o = b_i;
    endcase
  end

endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [DATA_W-1:0] alu_y_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mbr_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] ac_o,
  output logic [ADDR_W-1:0] pc_o
);

  logic [ADDR_W-1:0] mar_q, pc_q;
  logic [DATA_W-1:0] mbr_q, ir_q, ac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      ac_q  <= '0;
      pc_q  <= '0;
    end else begin
      if (ctrl_i.mar_from_pc)      mar_q <= pc_q;
      else if (ctrl_i.mar_from_ir) mar_q <= ir_q[ADDR_W-1:0];
      if (ctrl_i.mbr_ld) mbr_q <= mem_rdata_i;
      if (ctrl_i.ir_ld)  ir_q  <= mbr_q;
      if (ctrl_i.pc_inc) pc_q  <= pc_q + ADDR_W'(1);
      if (ctrl_i.ac_ld)  ac_q  <= alu_y_i;
    end
  end

  assign mar_o = mar_q;
  assign mbr_o = mbr_q;
  assign ir_o  = ir_q;
  assign ac_o  = ac_q;
  assign pc_o  = pc_q;

  p_pc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.pc_inc |=> pc_q == $past(pc_q) + ADDR_W'(1));
  p_pc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.pc_inc |=> $stable(pc_q));
  p_mar_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_i.mar_from_pc || ctrl_i.mar_from_ir) |=> $stable(mar_q));
  p_ac_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.ac_ld |=> $stable(ac_q));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [2:0]        state_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o
);

  state_e            state;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] mbr, ir, ac, alu_y;

  acc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (ir[DATA_W-1 -: OP_W]),
    .state_o  (state),
    .ctrl_o   (ctrl)
  );

  acc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata_i),
    .alu_y_i     (alu_y),
    .mar_o       (mem_addr_o),
    .mbr_o       (mbr),
    .ir_o        (ir),
    .ac_o        (ac),
    .pc_o        (pc_o)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i   (ac),
    .b_i   (mbr),
    .sel_i (ctrl.alu_sel),
    .y_o   (alu_y)
  );

  assign state_o  = state;
  assign halted_o = (state == ST_HALT);
  assign acc_o    = ac;

  p_halt_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o && $stable(acc_o) && $stable(pc_o) && $stable(mem_addr_o));

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [2:0]  state;
  logic        halted;
  logic [15:0] acc;
  logic [11:0] pc;
  logic [15:0] mem [4096];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  acc_cpu uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_addr_o  (mem_addr),
    .mem_rdata_i (mem_rdata),
    .state_o     (state),
    .halted_o    (halted),
    .acc_o       (acc),
    .pc_o        (pc)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Runs one instruction from state 0 to the next state 0 or 7
  task automatic run_instr(string req, int exp_cyc, int exp_acc, int exp_pc, int exp_xaddr);
    int cyc = 0;
    int faddr = -1;
    int xaddr = -1;
    bit addr_bad = 1'b0;
    bit acc_bad = 1'b0;
    logic [2:0]  ps;
    logic [11:0] pa;
    logic [15:0] pacc;
    do begin
      ps = state; pa = mem_addr; pacc = acc;
      @(negedge clk);
      cyc++;
      if (mem_addr != pa && ps != 3'd0 && ps != 3'd4) addr_bad = 1'b1;
      if (acc != pacc && ps != 3'd6) acc_bad = 1'b1;
      if (state == 3'd1) faddr = int'(mem_addr);
      if (state == 3'd5) xaddr = int'(mem_addr);
    end while (state != 3'd0 && state != 3'd7 && cyc < 50);
    check(req, "cycle count", cyc, exp_cyc);
    check(req, "accumulator", int'(acc), exp_acc);
    check("R3", "pc after instruction", int'(pc), exp_pc);
    check("R2", "fetch address", faddr, exp_pc - 1);
    if (exp_xaddr >= 0) check("R4", "operand address", xaddr, exp_xaddr);
    check("R10", "address moved outside load edges", int'(addr_bad), 0);
    check("R11", "accumulator moved outside write edge", int'(acc_bad), 0);
  endtask

  task automatic test_reset_and_fetch();
    clear_mem();
    mem[0]      = 16'h1010;
    mem[12'h010] = 16'hBEEF;
    mem[1]      = 16'hF000;
    rst_n = 1'b0;
    #35;
    check("R1", "state in reset", int'(state), 0);
    check("R1", "pc in reset", int'(pc), 0);
    check("R1", "acc in reset", int'(acc), 0);
    check("R1", "addr in reset", int'(mem_addr), 0);
    check("R1", "halted in reset", int'(halted), 0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R2", "state after release", int'(state), 0);
    @(negedge clk); check("R2", "state step 1", int'(state), 1);
    check("R2", "address from pc", int'(mem_addr), 0);
    check("R3", "pc held in state 1", int'(pc), 0);
    @(negedge clk); check("R2", "state step 2", int'(state), 2);
    check("R3", "pc held in state 2", int'(pc), 0);
    @(negedge clk); check("R2", "state step 3", int'(state), 3);
    check("R3", "pc held in decode", int'(pc), 0);
    @(negedge clk); check("R4", "state after LOAD decode", int'(state), 4);
    check("R3", "pc after decode", int'(pc), 1);
    @(negedge clk); check("R4", "state step 5", int'(state), 5);
    check("R4", "operand address", int'(mem_addr), 'h010);
    @(negedge clk); check("R4", "state step 6", int'(state), 6);
    check("R11", "acc before write", int'(acc), 0);
    @(negedge clk); check("R5", "back to fetch", int'(state), 0);
    check("R5", "loaded value", int'(acc), 'hBEEF);
  endtask

  task automatic test_arith();
    clear_mem();
    mem[0] = 16'h1080; mem[1] = 16'h2081; mem[2] = 16'h3082; mem[3] = 16'hF000;
    mem[12'h080] = 16'h1234; mem[12'h081] = 16'h0011; mem[12'h082] = 16'h0003;
    do_reset();
    run_instr("R5", 7, 'h1234, 1, 'h080);
    run_instr("R6", 7, 'h1245, 2, 'h081);
    run_instr("R7", 7, 'h36CF, 3, 'h082);
    run_instr("R9", 4, 'h36CF, 4, -1);
    check("R9", "halt state", int'(state), 7);
    check("R9", "halted flag", int'(halted), 1);
  endtask

  task automatic test_wrap();
    clear_mem();
    mem[0] = 16'h1FFE; mem[1] = 16'h2FFD; mem[2] = 16'h1FFC; mem[3] = 16'h3FFB; mem[4] = 16'hF000;
    mem[12'hFFE] = 16'hFFF0; mem[12'hFFD] = 16'h0020;
    mem[12'hFFC] = 16'h1234; mem[12'hFFB] = 16'h0100;
    do_reset();
    run_instr("R5", 7, 'hFFF0, 1, 'hFFE);
    run_instr("R6", 7, 'h0010, 2, 'hFFD);
    run_instr("R5", 7, 'h1234, 3, 'hFFC);
    run_instr("R7", 7, 'h3400, 4, 'hFFB);
    run_instr("R9", 4, 'h3400, 5, -1);
  endtask

  task automatic test_nop_and_halt();
    clear_mem();
    mem[0] = 16'h1050; mem[1] = 16'h0123; mem[2] = 16'h4456; mem[3] = 16'hE789; mem[4] = 16'hF000;
    mem[12'h050] = 16'h5A5A;
    mem[12'h123] = 16'h1111; mem[12'h456] = 16'h2222; mem[12'h789] = 16'h3333;
    do_reset();
    run_instr("R5", 7, 'h5A5A, 1, 'h050);
    run_instr("R8", 4, 'h5A5A, 2, -1);
    run_instr("R8", 4, 'h5A5A, 3, -1);
    run_instr("R8", 4, 'h5A5A, 4, -1);
    run_instr("R9", 4, 'h5A5A, 5, -1);
    for (int i = 0; i < 6; i++) mem[i] = 16'h1050;
    mem[12'h050] = 16'h0001;
    mem[12'h004] = 16'h2050;
    repeat (8) @(negedge clk);
    check("R9", "state stays halted", int'(state), 7);
    check("R9", "halted flag held", int'(halted), 1);
    check("R9", "pc frozen", int'(pc), 5);
    check("R9", "acc frozen", int'(acc), 'h5A5A);
    check("R10", "address frozen in halt", int'(mem_addr), 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R9: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    test_reset_and_fetch();
    test_arith();
    test_wrap();
    test_nop_and_halt();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule